// File: doc/BRIEF.md
# ADC Conversion Sequencer with Control/Status Register

This block is the digital control side of an analog-to-digital converter. Software sees one 8-bit control/status register and two result bytes through a small register port. The block turns writes to the control register into start strobes for the converter. When the converter reports completion, the block latches the converter's 10-bit result and raises a completion flag. That flag, together with a local enable and a global enable, forms the interrupt request.

The first start after the converter is switched on is automatically preceded by a longer initialisation conversion. The busy indication covers both conversions. The result of the initialisation run is discarded. In free-running mode the block restarts the converter after every completion until software clears the mode bit. Clearing the enable bit shuts the converter off and abandons any conversion in flight.

The converter itself, the clock divider and input channel selection sit outside this block. The block only holds the divider select code and presents it on a port.

Top module: `adc_ctrl_seq`

## Requirements
- R1: The control register (address 0) holds enable in bit 7, start/busy in bit 6, free-running in bit 5, completion flag in bit 4, interrupt enable in bit 3 and divider select in bits 2:0. Every bit resets to 0, and bits 7, 5, 3 and 2:0 read back as last written.
- R2: A control write with bit 7 clear turns the converter off from the next cycle (`conv_en` low). It ends any running conversion at once, with no flag set and no result update.
- R3: In single mode, each accepted start write produces exactly one result-producing conversion, after which the block goes idle.
- R4: A start issued while the enable bit is off-to-on in the same write, or as the first start since the enable bit was last set, is sent with `conv_init` high. The block then issues the real conversion; later starts carry `conv_init` low.
- R5: Bit 6 reads 1 from the cycle after an accepted start write until the result-producing conversion completes, including across an initialisation run.
- R6: Writing 0 to bit 6 has no effect. A start write while busy, or while the enable bit is 0, is ignored.
- R7: With bit 5 set, every completion immediately restarts the converter and updates the result. Clearing bit 5 lets the current conversion finish, then the block goes idle.
- R8: The flag is set, and the result is latched, on completion of a real conversion only. The end of an initialisation run changes neither.
- R9: The flag is cleared by writing 1 to bit 4 or by a pulse on `irq_ack`. Writing 0 to bit 4 leaves it unchanged.
- R10: `irq` is high exactly when the flag, bit 3 and `gie` are all 1.
- R11: `ps_sel` equals bits 2:0 of the control register. With it, the attached converter runs 13 divided clocks per conversion and 25 per initialisation run, where code 0 and code 1 both divide by 2 and codes 2 to 7 divide by 2 to the power of the code.
- R12: Address 1 reads result bits 7:0. Address 2 reads result bits 9:8 in its bits 1:0, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 control, 1 result low, 2 result high |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Interrupt request |
| conv_en | output | 1 | Converter power/enable |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_init | output | 1 | Marks the start as an initialisation run |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_result | input | 10 | Converter result, valid with `conv_done` |
| ps_sel | output | 3 | Divider select code |

## Verification
The bench drives a cycle-counting converter model and tries the following patterns:
- A start right after enabling, which tells whether the initialisation run is inserted and whether busy covers it.
- A start with enable and start set in one write.
- Repeat starts once the converter is warm, which must skip initialisation.
- Free-running bursts stopped mid-stream, which separate "finish the current conversion" from "stop at once".
- An abort mid-conversion, which must leave the result and flag untouched.
- Writes of 0 to the start bit, starts while busy and starts while disabled, which must all be ignored.
- Flag handling under write-one, write-zero and acknowledge, with each interrupt gate toggled on its own.

A change of divider code, checked through total conversion time, shows that the select reaches the port.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_INIT = 2'd1,
        SQ_CONV = 2'd2
    } sq_state_e;

    localparam int PS_W   = 3;
    localparam int B_EN   = 7;
    localparam int B_GO   = 6;
    localparam int B_FR   = 5;
    localparam int B_FLAG = 4;
    localparam int B_IE   = 3;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LO   = 2'd1;
    localparam logic [1:0] A_HI   = 2'd2;

    typedef struct packed {
        logic            en;
        logic            fr;
        logic            ie;
        logic            flag;
        logic [PS_W-1:0] ps;
        logic            need_init;
        sq_state_e       st;
        logic            start_p;
        logic            init_p;
    } sq_regs_t;

endpackage

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic [7:0]      wdata,
    input  logic            irq_ack,
    input  logic            conv_done,
    output logic            en,
    output logic            busy,
    output logic            fr,
    output logic            flag,
    output logic            ie,
    output logic [PS_W-1:0] ps,
    output logic            conv_start,
    output logic            conv_init,
    output logic            res_load
);

    sq_regs_t q, d;

    always_comb begin
        d         = q;
        d.start_p = 1'b0;
        d.init_p  = 1'b0;
        res_load  = 1'b0;

        // register field updates from a control write
        if (ctl_wr) begin
            d.en = wdata[B_EN];
            d.fr = wdata[B_FR];
            d.ie = wdata[B_IE];
            d.ps = wdata[PS_W-1:0];
            if (wdata[B_FLAG]) d.flag = 1'b0;
            if (wdata[B_EN] && !q.en) d.need_init = 1'b1;
        end
        if (irq_ack) d.flag = 1'b0;

        if (!d.en) begin
            // shut down: abandon whatever is running
            d.st = SQ_IDLE;
        end else begin
            if (conv_done && q.st == SQ_INIT) begin
                d.st      = SQ_CONV;
                d.start_p = 1'b1;
            end else if (conv_done && q.st == SQ_CONV) begin
                d.flag   = 1'b1;
                res_load = 1'b1;
                if (d.fr) d.start_p = 1'b1;
                else      d.st      = SQ_IDLE;
            end else if (ctl_wr && wdata[B_GO] && q.st == SQ_IDLE) begin
                d.start_p = 1'b1;
                if (d.need_init) begin
                    d.init_p    = 1'b1;
                    d.need_init = 1'b0;
                    d.st        = SQ_INIT;
                end else begin
                    d.st = SQ_CONV;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{en: 1'b0, fr: 1'b0, ie: 1'b0, flag: 1'b0, ps: '0,
                   need_init: 1'b0, st: SQ_IDLE, start_p: 1'b0, init_p: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign en         = q.en;
    assign busy       = (q.st != SQ_IDLE);
    assign fr         = q.fr;
    assign flag       = q.flag;
    assign ie         = q.ie;
    assign ps         = q.ps;
    assign conv_start = q.start_p;
    assign conv_init  = q.init_p;

endmodule

// File: rtl/adc_res_hold.sv
module adc_res_hold #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] din,
    output logic [RES_W-1:0] dout
);

    logic [RES_W-1:0] res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (load) res_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign dout = res_q;

endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int RES_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              gie,
    input  logic              irq_ack,
    output logic              irq,
    output logic              conv_en,
    output logic              conv_start,
    output logic              conv_init,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic [PS_W-1:0]   ps_sel
);

    localparam int HI_W = RES_W - DATA_W;

    logic ctl_wr;
    logic en_b, busy_b, fr_b, flag_b, ie_b;
    logic [PS_W-1:0] ps_b;
    logic res_load;
    logic [RES_W-1:0] res_val;

    assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTRL));

    adc_seq_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .wdata      (bus_wdata),
        .irq_ack    (irq_ack),
        .conv_done  (conv_done),
        .en         (en_b),
        .busy       (busy_b),
        .fr         (fr_b),
        .flag       (flag_b),
        .ie         (ie_b),
        .ps         (ps_b),
        .conv_start (conv_start),
        .conv_init  (conv_init),
        .res_load   (res_load)
    );

    adc_res_hold #(.RES_W(RES_W)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (res_load),
        .din   (conv_result),
        .dout  (res_val)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(A_CTRL): bus_rdata = {en_b, busy_b, fr_b, flag_b, ie_b, ps_b};
            ADDR_W'(A_LO):   bus_rdata = res_val[DATA_W-1:0];
            ADDR_W'(A_HI):   bus_rdata = {{(DATA_W-HI_W){1'b0}}, res_val[RES_W-1:DATA_W]};
            default:         bus_rdata = '0;
        endcase
    end

    assign irq     = flag_b && ie_b && gie;
    assign conv_en = en_b;
    assign ps_sel  = ps_b;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int RES_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              gie,
    input logic              irq_ack,
    input logic              irq,
    input logic              conv_en,
    input logic              conv_start,
    input logic              conv_init,
    input logic              conv_done,
    input logic [RES_W-1:0]  res_val
);

    // R2
    off_write_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && !bus_wdata[7]) |=> (!conv_en && !conv_start));

    // R4
    init_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && bus_wdata[7] && bus_wdata[6] && !conv_en)
        |=> (conv_start && conv_init));

    // R6
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_en);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(res_val));

    // R9
    ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !conv_done) |=> !irq);

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie);

endmodule

bind adc_ctrl_seq adc_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .gie        (gie),
    .irq_ack    (irq_ack),
    .irq        (irq),
    .conv_en    (conv_en),
    .conv_start (conv_start),
    .conv_init  (conv_init),
    .conv_done  (conv_done),
    .res_val    (res_val)
);

// File: tb/adc_ctrl_seq_bench.sv
module adc_ctrl_seq_bench;

    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic       conv_en, conv_start, conv_init;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic [2:0] ps_sel;

    int n_tests = 0;
    int n_fail  = 0;

    // converter model bookkeeping
    int         n_init_st = 0;
    int         n_real_st = 0;
    int         n_real_dn = 0;
    logic [9:0] exp_res   = '0;

    adc_ctrl_seq u_adc_ctrl_seq (
        .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
        .gie, .irq_ack, .irq, .conv_en, .conv_start, .conv_init,
        .conv_done, .conv_result, .ps_sel
    );

    always #(CLK_NS/2) clk = ~clk;

    // Converter model: counts divided clocks, acts on negative edges
    initial begin
        bit    active;
        bit    is_init;
        int    cnt;
        int    div;
        active = 0; is_init = 0; cnt = 0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (!conv_en) begin
                active = 0;
            end else if (active) begin
                cnt--;
                if (cnt == 0) begin
                    active = 0;
                    conv_done = 1'b1;
                    if (is_init) begin
                        conv_result = 10'h3FF;
                    end else begin
                        exp_res = 10'h0A5 + 10'(37 * (n_real_dn + 1));
                        conv_result = exp_res;
                        n_real_dn++;
                    end
                end
            end
            if (conv_start) begin
                div = (ps_sel == 3'd0) ? 2 : (1 << ps_sel);
                is_init = conv_init;
                cnt = (conv_init ? 25 : 13) * div;
                active = 1;
                if (conv_init) n_init_st++;
                else           n_real_st++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle(output int cyc);
        logic [7:0] v;
        cyc = 0;
        rd_reg(2'd0, v);
        while (v[6] && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            rd_reg(2'd0, v);
        end
    endtask

    task automatic wait_done_count(input int target);
        int guard;
        guard = 0;
        while (n_real_dn < target && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_reg(2'd0, v); check(v == 8'h00, "R1 reset ctrl", v, 0);
        rd_reg(2'd1, v); check(v == 8'h00, "R12 reset lo", v, 0);
        rd_reg(2'd2, v); check(v == 8'h00, "R12 reset hi", v, 0);
        check(irq == 1'b0, "R10 reset irq", irq, 0);
    endtask

    task automatic t_first_start;
        logic [7:0] v;
        int c, bi, br, bd;
        wr_reg(2'd0, 8'h80);
        rd_reg(2'd0, v); check(v == 8'h80, "R1 enable readback", v, 8'h80);
        bi = n_init_st; br = n_real_st; bd = n_real_dn;
        wr_reg(2'd0, 8'hC0);
        rd_reg(2'd0, v); check(v[6] == 1'b1, "R5 busy after start", v[6], 1);
        idle_cycles(30);
        rd_reg(2'd0, v); check(v[6] == 1'b1, "R5 busy during init run", v[6], 1);
        wait_idle(c);
        check(n_init_st == bi + 1, "R4 init run inserted", n_init_st - bi, 1);
        check(n_real_st == br + 1, "R3 one real conversion", n_real_st - br, 1);
        check(n_real_dn == bd + 1, "R5 busy until real done", n_real_dn - bd, 1);
        rd_reg(2'd1, v); check(v == exp_res[7:0], "R12 low byte", v, exp_res[7:0]);
        rd_reg(2'd2, v); check(v == {6'b0, exp_res[9:8]}, "R12 high byte", v, exp_res[9:8]);
        rd_reg(2'd0, v); check(v == 8'h90, "R8 flag set idle", v, 8'h90);
    endtask

    task automatic t_zero_start;
        logic [7:0] v;
        int c, bi, br;
        bi = n_init_st; br = n_real_st;
        wr_reg(2'd0, 8'hC0);
        idle_cycles(5);
        wr_reg(2'd0, 8'h80);
        rd_reg(2'd0, v); check(v[6] == 1'b1, "R6 zero start keeps busy", v[6], 1);
        wr_reg(2'd0, 8'hC0);
        wait_idle(c);
        check(n_init_st == bi, "R4 no init when warm", n_init_st - bi, 0);
        check(n_real_st == br + 1, "R6 start while busy ignored", n_real_st - br, 1);
        rd_reg(2'd0, v); check(v[4] == 1'b1, "R9 write zero keeps flag", v[4], 1);
        wr_reg(2'd0, 8'h90);
        rd_reg(2'd0, v); check(v[4] == 1'b0, "R9 write one clears flag", v[4], 0);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        int c;
        gie = 1'b0;
        wr_reg(2'd0, 8'hC8);
        wait_idle(c);
        #1; check(irq == 1'b0, "R10 gie low masks", irq, 0);
        gie = 1'b1;
        #1; check(irq == 1'b1, "R10 all gates set", irq, 1);
        wr_reg(2'd0, 8'h88);
        #1; check(irq == 1'b1, "R9 write zero keeps irq", irq, 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        #1; check(irq == 1'b0, "R9 ack clears irq", irq, 0);
        rd_reg(2'd0, v); check(v[4] == 1'b0, "R9 ack clears flag", v[4], 0);
        wr_reg(2'd0, 8'hC0);
        wait_idle(c);
        #1; check(irq == 1'b0, "R10 ie low masks", irq, 0);
        wr_reg(2'd0, 8'h90);
        gie = 1'b0;
    endtask

    task automatic t_free_run;
        logic [7:0] v;
        int c, base, bs;
        base = n_real_dn;
        wr_reg(2'd0, 8'hE0);
        for (int k = 1; k <= 3; k++) begin
            wait_done_count(base + k);
            idle_cycles(2);
            rd_reg(2'd1, v); check(v == exp_res[7:0], "R7 free-run result update", v, exp_res[7:0]);
            rd_reg(2'd0, v); check(v[6] == 1'b1, "R7 free-run stays busy", v[6], 1);
        end
        base = n_real_dn;
        wr_reg(2'd0, 8'h80);
        wait_idle(c);
        check(n_real_dn == base + 1, "R7 current conversion finishes", n_real_dn - base, 1);
        bs = n_real_st;
        idle_cycles(60);
        check(n_real_st == bs, "R7 no restart after stop", n_real_st - bs, 0);
        wr_reg(2'd0, 8'h90);
    endtask

    task automatic t_abort;
        logic [7:0] v;
        int c, bd, bi;
        logic [7:0] lo_before;
        rd_reg(2'd1, lo_before);
        bd = n_real_dn;
        wr_reg(2'd0, 8'hC0);
        idle_cycles(10);
        wr_reg(2'd0, 8'h00);
        rd_reg(2'd0, v); check(v == 8'h00, "R2 abort clears busy", v, 0);
        check(conv_en == 1'b0, "R2 converter off", conv_en, 0);
        idle_cycles(40);
        check(n_real_dn == bd, "R2 no completion after abort", n_real_dn - bd, 0);
        rd_reg(2'd1, v); check(v == lo_before, "R2 result unchanged", v, lo_before);
        rd_reg(2'd0, v); check(v[4] == 1'b0, "R2 flag not set", v[4], 0);
        bi = n_init_st;
        wr_reg(2'd0, 8'hC0);
        wait_idle(c);
        check(n_init_st == bi + 1, "R4 init on same-write enable", n_init_st - bi, 1);
        wr_reg(2'd0, 8'h90);
    endtask

    task automatic t_disabled_start;
        logic [7:0] v;
        int bs;
        wr_reg(2'd0, 8'h00);
        bs = n_real_st + n_init_st;
        wr_reg(2'd0, 8'h40);
        idle_cycles(5);
        rd_reg(2'd0, v); check(v == 8'h00, "R6 start while disabled", v, 0);
        check(n_real_st + n_init_st == bs, "R6 no strobe while disabled", n_real_st + n_init_st - bs, 0);
    endtask

    task automatic t_prescale;
        logic [7:0] v;
        int c;
        wr_reg(2'd0, 8'h85);
        rd_reg(2'd0, v); check(v == 8'h85, "R1 divider readback", v, 8'h85);
        check(ps_sel == 3'd5, "R11 ps_sel port", ps_sel, 5);
        wr_reg(2'd0, 8'hC2);
        wait_idle(c);
        check(c >= 150 && c <= 160, "R11 divide-by-4 timing", c, 155);
        wr_reg(2'd0, 8'h10);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(2);
        t_reset();
        t_first_start();
        t_zero_start();
        t_irq();
        t_free_run();
        t_abort();
        t_disabled_start();
        t_prescale();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule